// File: doc/BRIEF.md
# I2C Transfer Header Decoder

This block sits between a 32-bit transmit word queue and an I2C bus engine. Every transfer arrives through the same data path as its payload, as three leading header words. The first is a generic word carrying a header size, a packet identifier, a controller identifier and a protocol marker. The second gives the payload length. The third gives the target address and the per-transfer bus controls. The block decodes these words into a registered transfer descriptor, announced by a one-cycle strobe. For a write transfer it then unpacks the payload words into a byte stream for the bit engine.

Both data interfaces use valid/ready handshakes. A word moves on the input side in a cycle where `in_valid` and `in_ready` are both high. A byte moves on the output side in a cycle where `byte_valid` and `byte_ready` are both high. Back-pressure is strict in both directions:
- `in_ready` is never high while the downstream side refuses bytes.
- `in_ready` is never high while a payload word is still being unpacked.
- A presented byte, along with its `byte_data` and `byte_last`, holds steady until it is taken.

A read transfer has no payload words. Its descriptor is issued on its own, and the next word is taken as a new generic header.

Top module: `i2c_pkt_hdr_parser`

## Requirements
- R1: During and straight after reset, `desc_valid`, `byte_valid` and `hdr_err` are low, and `in_ready` follows `byte_ready`.
- R2: From the accepted generic word, bits 31:28 become `desc_hdr_size`, bits 23:16 become `desc_pkt_id` and bits 15:12 become `desc_ctrl_id`. Bit 4 must be set for the word to count as an I2C header.
- R3: A generic-position word with bit 4 clear raises `hdr_err` for exactly the following cycle and is dropped. The next word is again decoded as a generic header, and no descriptor results from the dropped word.
- R4: `desc_len` equals the low LEN_W bits of the length word plus one, so it ranges from 1 to 2^LEN_W (4096 at LEN_W=12). Bits above the field are ignored.
- R5: The protocol word flags map as follows:
  - bit 22 to `desc_hs`
  - bit 21 to `desc_cont_nack`
  - bit 20 to `desc_start_byte`
  - bit 19 to `desc_read`
  - bit 18 to `desc_ten_bit`
  - bit 17 to `desc_irq_en`
- R6: With bit 18 clear, `desc_addr` is protocol-word bits 7:1 with zero upper bits, and bit 0 is ignored. With bit 18 set, `desc_addr` is bits 9:0.
- R7: `desc_end` is 2 (continue, no stop, no restart) when bit 15 is set. Otherwise it is 1 (repeated start) when bit 16 is set, and otherwise 0 (STOP). Continue wins when both bits are set, and the value 3 never appears.
- R8: `desc_valid` is high for exactly the one cycle after the protocol word is accepted. The descriptor fields hold their values until the next descriptor.
- R9: Payload words are unpacked into bytes in order:
  - bits 7:0 first, then 15:8, 23:16 and 31:24;
  - exactly `desc_len` bytes are emitted, with `byte_last` high only on the final byte;
  - unused lanes of the final word are dropped;
  - the next word is then a generic header.
- R10: After a read descriptor no payload is consumed, and the very next word is decoded as a generic header.
- R11: `in_ready` is low in every cycle where `byte_ready` is low or a byte is being presented.
- R12: While `byte_valid` is high and `byte_ready` low, `byte_valid`, `byte_data` and `byte_last` stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word may be taken this cycle |
| in_data | input | 32 | Header or payload word |
| byte_valid | output | 1 | Payload byte offered |
| byte_ready | input | 1 | Downstream takes a byte this cycle |
| byte_data | output | 8 | Payload byte |
| byte_last | output | 1 | Final byte of the transfer |
| desc_valid | output | 1 | One-cycle descriptor strobe |
| desc_hdr_size | output | 4 | Header size field |
| desc_pkt_id | output | 8 | Packet identifier |
| desc_ctrl_id | output | 4 | Controller identifier |
| desc_len | output | LEN_W+1 | Payload byte count (1..2^LEN_W) |
| desc_addr | output | 10 | Target address |
| desc_ten_bit | output | 1 | 10-bit addressing |
| desc_read | output | 1 | Read transfer |
| desc_hs | output | 1 | High-speed mode requested |
| desc_cont_nack | output | 1 | Continue on NACK |
| desc_start_byte | output | 1 | Send start byte |
| desc_irq_en | output | 1 | Interrupt enable |
| desc_end | output | 2 | End action: 0 STOP, 1 repeated start, 2 continue |
| hdr_err | output | 1 | One-cycle pulse for a dropped non-I2C generic word |

## Verification
The bench builds the block with its default LEN_W of 12. This makes the largest legal count reachable: an all-ones length field gives 4096, carried on a read descriptor without streaming 4096 bytes. At this width the junk bits placed above the length field show that they are ignored. Short write packets of 1, 3, 4 and 6 bytes place the end of the payload in each lane position, including partial final words. A stall in the middle of a packet exercises the hold rules on both handshakes.

// File: rtl/i2c_hdr_pkg.sv
package i2c_hdr_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;
  localparam int LANE_W = $clog2(LANES + 1);

  // generic word field positions
  localparam int GEN_SIZE_LO = 28;
  localparam int GEN_ID_LO   = 16;
  localparam int GEN_CTRL_LO = 12;
  localparam int GEN_I2C_BIT = 4;

  // protocol word flag positions
  localparam int PW_HS       = 22;
  localparam int PW_NACK_OK  = 21;
  localparam int PW_STARTB   = 20;
  localparam int PW_READ     = 19;
  localparam int PW_TEN      = 18;
  localparam int PW_IRQ      = 17;
  localparam int PW_RESTART  = 16;
  localparam int PW_CONTINUE = 15;

  typedef enum logic [1:0] {
    END_STOP     = 2'd0,
    END_RESTART  = 2'd1,
    END_CONTINUE = 2'd2
  } end_kind_e;

  typedef enum logic [1:0] {
    ST_GENERIC,
    ST_LENGTH,
    ST_PROTO,
    ST_PAYLOAD
  } parse_st_e;

  typedef struct packed {
    logic      hs;
    logic      cont_nack;
    logic      start_byte;
    logic      rd;
    logic      ten_bit;
    logic      irq_en;
    end_kind_e end_kind;
    logic [9:0] addr;
  } proto_fields_t;
endpackage

// File: rtl/i2c_proto_decode.sv
module i2c_proto_decode
  import i2c_hdr_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output proto_fields_t     fields_o
);
  logic unused_dec;
  assign unused_dec = ^word_i;

  always_comb begin
    fields_o.hs         = word_i[PW_HS];
    fields_o.cont_nack  = word_i[PW_NACK_OK];
    fields_o.start_byte = word_i[PW_STARTB];
    fields_o.rd         = word_i[PW_READ];
    fields_o.ten_bit    = word_i[PW_TEN];
    fields_o.irq_en     = word_i[PW_IRQ];
    // continue takes priority over repeated start
    if (word_i[PW_CONTINUE])      fields_o.end_kind = END_CONTINUE;
    else if (word_i[PW_RESTART])  fields_o.end_kind = END_RESTART;
    else                          fields_o.end_kind = END_STOP;
    if (word_i[PW_TEN]) fields_o.addr = word_i[9:0];
    else                fields_o.addr = {3'b000, word_i[7:1]};
  end
endmodule

// File: rtl/i2c_hdr_fsm.sv
module i2c_hdr_fsm
  import i2c_hdr_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire_i,
  input  logic [WORD_W-1:0]   word_i,
  input  proto_fields_t       fields_i,
  output parse_st_e           state_o,
  output logic                desc_valid_o,
  output logic [3:0]          hsize_o,
  output logic [7:0]          pid_o,
  output logic [3:0]          cid_o,
  output logic [LEN_W:0]      len_o,
  output proto_fields_t       fields_o,
  output logic                hdr_err_o,
  output logic                load_o,
  output logic [LANE_W-1:0]   load_n_o,
  output logic                load_last_o
);
  localparam int CNT_W = LEN_W + 1;

  parse_st_e        st_q;
  logic [3:0]       stg_hsize_q;
  logic [7:0]       stg_pid_q;
  logic [3:0]       stg_cid_q;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] rem_q;
  logic [LANE_W-1:0] nb;
  logic             last_chunk;
  logic             unused_fsm;

  assign unused_fsm = ^word_i;
  assign state_o    = st_q;
  assign last_chunk = (rem_q <= CNT_W'(LANES));

  always_comb begin
    if (rem_q >= CNT_W'(LANES)) nb = LANE_W'(LANES);
    else                        nb = rem_q[LANE_W-1:0];
  end

  assign load_o      = fire_i && (st_q == ST_PAYLOAD);
  assign load_n_o    = nb;
  assign load_last_o = last_chunk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_GENERIC;
      stg_hsize_q  <= '0;
      stg_pid_q    <= '0;
      stg_cid_q    <= '0;
      len_q        <= '0;
      rem_q        <= '0;
      desc_valid_o <= 1'b0;
      hsize_o      <= '0;
      pid_o        <= '0;
      cid_o        <= '0;
      len_o        <= '0;
      fields_o     <= '0;
      hdr_err_o    <= 1'b0;
    end else begin
      desc_valid_o <= 1'b0;
      hdr_err_o    <= 1'b0;
      if (fire_i) begin
        case (st_q)
          ST_GENERIC: begin
            if (word_i[GEN_I2C_BIT]) begin
              stg_hsize_q <= word_i[GEN_SIZE_LO +: 4];
              stg_pid_q   <= word_i[GEN_ID_LO +: 8];
              stg_cid_q   <= word_i[GEN_CTRL_LO +: 4];
              st_q        <= ST_LENGTH;
            end else begin
              hdr_err_o   <= 1'b1;
            end
          end
          ST_LENGTH: begin
            len_q <= CNT_W'(word_i[LEN_W-1:0]) + CNT_W'(1);
            st_q  <= ST_PROTO;
          end
          ST_PROTO: begin
            desc_valid_o <= 1'b1;
            hsize_o      <= stg_hsize_q;
            pid_o        <= stg_pid_q;
            cid_o        <= stg_cid_q;
            len_o        <= len_q;
            fields_o     <= fields_i;
            rem_q        <= len_q;
            st_q         <= fields_i.rd ? ST_GENERIC : ST_PAYLOAD;
          end
          ST_PAYLOAD: begin
            rem_q <= rem_q - CNT_W'(nb);
            if (last_chunk) st_q <= ST_GENERIC;
          end
          default: st_q <= ST_GENERIC;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_byte_ser.sv
module i2c_byte_ser
  import i2c_hdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [LANE_W-1:0] count_i,
  input  logic              last_i,
  output logic              empty_o,
  output logic              byte_valid_o,
  input  logic              byte_ready_i,
  output logic [7:0]        byte_data_o,
  output logic              byte_last_o
);
  logic [WORD_W-1:0] buf_q;
  logic [LANE_W-1:0] left_q;
  logic              last_q;
  logic              full_q;

  assign empty_o      = !full_q;
  assign byte_valid_o = full_q;
  assign byte_data_o  = buf_q[7:0];
  assign byte_last_o  = full_q && last_q && (left_q == LANE_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      left_q <= '0;
      last_q <= 1'b0;
      full_q <= 1'b0;
    end else if (load_i) begin
      buf_q  <= word_i;
      left_q <= count_i;
      last_q <= last_i;
      full_q <= 1'b1;
    end else if (full_q && byte_ready_i) begin
      buf_q  <= buf_q >> 8;
      left_q <= left_q - LANE_W'(1);
      if (left_q == LANE_W'(1)) full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_pkt_hdr_parser.sv
module i2c_pkt_hdr_parser
  import i2c_hdr_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_data,
  output logic              byte_valid,
  input  logic              byte_ready,
  output logic [7:0]        byte_data,
  output logic              byte_last,
  output logic              desc_valid,
  output logic [3:0]        desc_hdr_size,
  output logic [7:0]        desc_pkt_id,
  output logic [3:0]        desc_ctrl_id,
  output logic [LEN_W:0]    desc_len,
  output logic [9:0]        desc_addr,
  output logic              desc_ten_bit,
  output logic              desc_read,
  output logic              desc_hs,
  output logic              desc_cont_nack,
  output logic              desc_start_byte,
  output logic              desc_irq_en,
  output logic [1:0]        desc_end,
  output logic              hdr_err
);
  proto_fields_t     dec_f;
  proto_fields_t     desc_f;
  parse_st_e         st;
  logic              fire;
  logic              ser_empty;
  logic              load;
  logic [LANE_W-1:0] load_n;
  logic              load_last;

  assign in_ready = byte_ready && ser_empty;
  assign fire     = in_valid && in_ready;

  i2c_proto_decode u_dec (
    .word_i   (in_data),
    .fields_o (dec_f)
  );

  i2c_hdr_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .fire_i       (fire),
    .word_i       (in_data),
    .fields_i     (dec_f),
    .state_o      (st),
    .desc_valid_o (desc_valid),
    .hsize_o      (desc_hdr_size),
    .pid_o        (desc_pkt_id),
    .cid_o        (desc_ctrl_id),
    .len_o        (desc_len),
    .fields_o     (desc_f),
    .hdr_err_o    (hdr_err),
    .load_o       (load),
    .load_n_o     (load_n),
    .load_last_o  (load_last)
  );

  i2c_byte_ser u_ser (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load),
    .word_i       (in_data),
    .count_i      (load_n),
    .last_i       (load_last),
    .empty_o      (ser_empty),
    .byte_valid_o (byte_valid),
    .byte_ready_i (byte_ready),
    .byte_data_o  (byte_data),
    .byte_last_o  (byte_last)
  );

  logic unused_st;
  assign unused_st = ^st;

  assign desc_addr       = desc_f.addr;
  assign desc_ten_bit    = desc_f.ten_bit;
  assign desc_read       = desc_f.rd;
  assign desc_hs         = desc_f.hs;
  assign desc_cont_nack  = desc_f.cont_nack;
  assign desc_start_byte = desc_f.start_byte;
  assign desc_irq_en     = desc_f.irq_en;
  assign desc_end        = desc_f.end_kind;
endmodule

// File: rtl/i2c_pkt_hdr_parser_chk.sv
module i2c_pkt_hdr_parser_chk #(
  parameter int LEN_W = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_ready,
  input logic           byte_valid,
  input logic           byte_ready,
  input logic [7:0]     byte_data,
  input logic           byte_last,
  input logic           desc_valid,
  input logic [LEN_W:0] desc_len,
  input logic [9:0]     desc_addr,
  input logic           desc_ten_bit,
  input logic [1:0]     desc_end,
  input logic           hdr_err
);
  // R11: no word is taken while downstream refuses bytes
  p_ready_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_ready |-> !in_ready);

  // R9: input waits while a word is still being unpacked
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> !in_ready);

  // R12: a stalled byte holds steady
  p_byte_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_ready) |=>
      (byte_valid && $stable(byte_data) && $stable(byte_last)));

  // R8: the descriptor strobe lasts one cycle
  p_desc_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |=> !desc_valid);

  // R3: a dropped word never coincides with a descriptor
  p_err_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |-> !desc_valid);

  // R4: length stays within 1 .. 2^LEN_W
  p_len_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> ((desc_len != '0) && (desc_len <= {1'b1, {LEN_W{1'b0}}})));

  // R6: 7-bit addresses leave the upper bits clear
  p_addr7_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !desc_ten_bit) |-> (desc_addr[9:7] == 3'b000));

  // R7: end action is never the unused code
  p_end_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> (desc_end != 2'd3));
endmodule

bind i2c_pkt_hdr_parser i2c_pkt_hdr_parser_chk #(.LEN_W(LEN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_ready     (in_ready),
  .byte_valid   (byte_valid),
  .byte_ready   (byte_ready),
  .byte_data    (byte_data),
  .byte_last    (byte_last),
  .desc_valid   (desc_valid),
  .desc_len     (desc_len),
  .desc_addr    (desc_addr),
  .desc_ten_bit (desc_ten_bit),
  .desc_end     (desc_end),
  .hdr_err      (hdr_err)
);

// File: tb/i2c_pkt_hdr_parser_bench.sv
`timescale 1ns/1ps
module i2c_pkt_hdr_parser_bench;
  localparam int LEN_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [31:0] in_data = '0;
  logic byte_valid;
  logic byte_ready = 1'b1;
  logic [7:0] byte_data;
  logic byte_last;
  logic desc_valid;
  logic [3:0] desc_hdr_size;
  logic [7:0] desc_pkt_id;
  logic [3:0] desc_ctrl_id;
  logic [LEN_W:0] desc_len;
  logic [9:0] desc_addr;
  logic desc_ten_bit, desc_read, desc_hs, desc_cont_nack, desc_start_byte, desc_irq_en;
  logic [1:0] desc_end;
  logic hdr_err;

  always #10 clk = ~clk;

  i2c_pkt_hdr_parser #(.LEN_W(LEN_W)) u_i2c_pkt_hdr_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data), .byte_last(byte_last),
    .desc_valid(desc_valid), .desc_hdr_size(desc_hdr_size), .desc_pkt_id(desc_pkt_id),
    .desc_ctrl_id(desc_ctrl_id), .desc_len(desc_len), .desc_addr(desc_addr),
    .desc_ten_bit(desc_ten_bit), .desc_read(desc_read), .desc_hs(desc_hs),
    .desc_cont_nack(desc_cont_nack), .desc_start_byte(desc_start_byte),
    .desc_irq_en(desc_irq_en), .desc_end(desc_end), .hdr_err(hdr_err)
  );

  typedef struct packed {
    logic [31:0] w0, w1, w2, p0, p1;
    logic [7:0]  pid;
    logic [3:0]  cid, hsz;
    logic [12:0] len;
    logic [9:0]  addr;
    logic [5:0]  flg;   // {hs, cont_nack, start_byte, read, ten_bit, irq_en}
    logic [1:0]  endk;
    logic [3:0]  nbytes;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{32'h0001_1010, 32'hABCD_E003, 32'h0002_00A0, 32'h4433_2211, 32'h0,
      8'h01, 4'h1, 4'h0, 13'd4, 10'h050, 6'b000001, 2'd0, 4'd4},
    '{32'h2005_3010, 32'h0000_0005, 32'h0021_007E, 32'hDDCC_BBAA, 32'h9988_1FEE,
      8'h05, 4'h3, 4'h2, 13'd6, 10'h03F, 6'b010000, 2'd1, 4'd6},
    '{32'h00FF_F010, 32'h0000_0FFF, 32'h005D_82A5, 32'h0, 32'h0,
      8'hFF, 4'hF, 4'h0, 13'd4096, 10'h2A5, 6'b101110, 2'd2, 4'd0},
    '{32'h3A7C_0010, 32'h0000_0000, 32'h0004_8155, 32'hA5A5_A5C3, 32'h0,
      8'h7C, 4'h0, 4'h3, 13'd1, 10'h155, 6'b000010, 2'd2, 4'd1},
    '{32'h0042_5010, 32'h0000_0002, 32'h0001_00FF, 32'h00C0_FFEE, 32'h0,
      8'h42, 4'h5, 4'h0, 13'd3, 10'h07F, 6'b000000, 2'd1, 4'd3}
  };

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int desc_cnt = 0;
  int err_cnt = 0;
  int cap_n = 0;
  logic [7:0] cap_b [0:15];
  logic       cap_l [0:15];
  logic [7:0] c_pid; logic [3:0] c_cid, c_hsz; logic [12:0] c_len;
  logic [9:0] c_addr; logic [5:0] c_flg; logic [1:0] c_end;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++; errors++;
      $display("FAIL R1 watchdog: actual=%0d expected<=%0d cycles", cycles, 50000);
      finish_run();
    end
  end

  // monitors sample mid-cycle
  always @(negedge clk) if (rst_n) begin
    if (desc_valid) begin
      desc_cnt++;
      c_pid = desc_pkt_id; c_cid = desc_ctrl_id; c_hsz = desc_hdr_size; c_len = desc_len;
      c_addr = desc_addr; c_end = desc_end;
      c_flg = {desc_hs, desc_cont_nack, desc_start_byte, desc_read, desc_ten_bit, desc_irq_en};
    end
    if (hdr_err) err_cnt++;
    if (byte_valid && byte_ready && cap_n < 16) begin
      cap_b[cap_n] = byte_data; cap_l[cap_n] = byte_last; cap_n++;
    end
  end

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1; in_data = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic check_packet(input vec_t v, input int d0);
    logic [63:0] pay;
    pay = {v.p1, v.p0};
    chk("R8", "descriptor count", desc_cnt, d0 + 1);
    chk("R2", "packet id", c_pid, v.pid);
    chk("R2", "controller id", c_cid, v.cid);
    chk("R2", "header size", c_hsz, v.hsz);
    chk("R4", "length", c_len, v.len);
    chk("R6", "address", c_addr, v.addr);
    chk("R5", "flags", c_flg, v.flg);
    chk("R7", "end action", c_end, v.endk);
    chk(v.flg[2] ? "R10" : "R9", "byte count", cap_n, v.nbytes);
    for (int k = 0; k < int'(v.nbytes); k++) begin
      chk("R9", "byte value", cap_b[k], pay[8*k +: 8]);
      chk("R9", "byte_last", cap_l[k], (k == int'(v.nbytes) - 1));
    end
  endtask

  task automatic run_vec(input vec_t v);
    int d0;
    int nw;
    d0 = desc_cnt; cap_n = 0;
    send(v.w0); send(v.w1); send(v.w2);
    nw = (int'(v.nbytes) + 3) / 4;
    if (nw > 0) send(v.p0);
    if (nw > 1) send(v.p1);
    idle(8);
    check_packet(v, d0);
  endtask

  initial begin
    idle(2);
    chk("R1", "desc_valid in reset", desc_valid, 0);
    chk("R1", "byte_valid in reset", byte_valid, 0);
    rst_n = 1'b1;
    idle(2);
    chk("R1", "hdr_err after reset", hdr_err, 0);
    chk("R1", "in_ready after reset", in_ready, 1);
    chk("R1", "desc_valid after reset", desc_valid, 0);

    // R3: non-I2C generic word is flagged and dropped
    send(32'h0001_1000);
    chk("R3", "hdr_err pulse", hdr_err, 1);
    @(negedge clk);
    chk("R3", "hdr_err cleared", hdr_err, 0);
    chk("R3", "no descriptor", desc_cnt, 0);

    // table walk (read in entry 2 followed by a header covers R10)
    for (int i = 0; i < 5; i++) run_vec(VECS[i]);
    chk("R3", "error pulse count", err_cnt, 1);

    // R8: strobe timing
    begin
      vec_t v;
      int d0;
      v = VECS[4]; d0 = desc_cnt; cap_n = 0;
      send(v.w0); send(v.w1);
      chk("R8", "no strobe before third word", desc_valid, 0);
      send(v.w2);
      chk("R8", "strobe after third word", desc_valid, 1);
      @(negedge clk);
      chk("R8", "strobe one cycle", desc_valid, 0);
      send(v.p0);
      idle(8);
      check_packet(v, d0);
    end

    // R11/R12: stall in the middle of a payload
    begin
      vec_t v;
      int d0;
      v = VECS[1]; d0 = desc_cnt; cap_n = 0;
      send(v.w0); send(v.w1); send(v.w2); send(v.p0);
      @(posedge clk); #1 byte_ready = 1'b0;
      @(negedge clk);
      in_valid = 1'b1; in_data = v.p1;
      for (int k = 0; k < 4; k++) begin
        chk("R11", "in_ready during stall", in_ready, 0);
        chk("R12", "byte held valid", byte_valid, 1);
        chk("R12", "byte held data", byte_data, 8'hBB);
        @(negedge clk);
      end
      @(posedge clk); #1 byte_ready = 1'b1;
      send(v.p1);
      idle(10);
      check_packet(v, d0);
      chk("R11", "in_ready after drain", in_ready, 1);
    end

    finish_run();
  end
endmodule